// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block converts one cache maintenance request into the string of single-line commands that a cache controller executes. A request names an operation (invalidate, clean or flush) and a byte range given by a start address and an end address. The sequencer walks that range in 32-byte lines. It presents each line command, made of a line address and a clean-or-invalidate code, on a valid/ready command port. After the last command has been taken, it signals a one-cycle completion barrier.

An invalidate or flush request that covers the whole address space is not walked line by line. It is passed to a separate full-cache set/way engine through a request/acknowledge pair. For an invalidate, lines that the range covers only in part are cleaned before they are invalidated, so dirty bytes that lie outside the range survive. Lines that lie wholly inside the range are invalidated without a clean.

A request is taken only while the block is idle. `busy` marks the time from acceptance until the barrier.

Top module: `cache_range_seq`

## Requirements
- R1: Clean request (`req_op`=1): the first line is the start address with its low 5 bits cleared. A command with `lop_code`=0 (clean) is issued for that line and for each following line 32 bytes on, while the line address is below `req_end`. No command is issued when the first line is not below `req_end`.
- R2: Flush request (`req_op`=2): the lines are chosen as in R1. Each line gets a clean (`lop_code`=0) and then, as the very next command, an invalidate (`lop_code`=1) of the same line.
- R3: Invalidate request (`req_op`=0) whose start has non-zero low 5 bits: the line containing the start first gets a clean and then an invalidate. The walk then resumes at the next line boundary.
- R4: Invalidate request: each line whose address is below `req_end` with its low 5 bits cleared gets a single invalidate and no clean.
- R5: Invalidate request: if the walk position is still below `req_end` after the full lines, that last line gets a clean and then an invalidate.
- R6: An invalidate or flush request with start 0 and end all ones issues no line commands. It raises `walk_req` and holds it, with `walk_flush` stable (1 for flush, 0 for invalidate), until `walk_ack` is sampled high.
- R7: `done` is a single-cycle pulse. It comes in the cycle after the last command handshake, in the cycle after the `walk_ack` cycle, or two cycles after acceptance when the request yields no command. `busy` is low in the `done` cycle.
- R8: A request is accepted only in a cycle where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until `done`. A `req_valid` raised while busy has no effect, and no command appears while idle.
- R9: While `lop_valid` is high and `lop_ready` is low, `lop_valid`, `lop_addr` and `lop_code` hold their values into the next cycle.
- R10: `req_op`=3 is accepted but issues no line command and no walk request. It completes through `done` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 none |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Byte address one past the range |
| busy | output | 1 | Request in progress |
| lop_valid | output | 1 | Line command present |
| lop_ready | input | 1 | Line command taken when high with lop_valid |
| lop_addr | output | ADDR_W | Line-aligned address of the command |
| lop_code | output | 1 | 0 clean, 1 invalidate |
| walk_req | output | 1 | Whole-cache operation request |
| walk_flush | output | 1 | 1: clean and invalidate all, 0: invalidate all |
| walk_ack | input | 1 | Whole-cache operation finished |
| done | output | 1 | Completion barrier pulse |

## Verification
Two functions can fall in the same cycle: the barrier of one request and the acceptance of the next. The bench holds a second request on `req_valid` for the whole life of the first, so the second is taken in exactly the cycle where `done` pulses and `busy` is low. The per-clock model must then see the barrier on time and the second command stream with no gap or duplicate. A separate run lowers `lop_ready` on a fixed pattern, so that stalls land on a clean/invalidate pair and on the final command just before the barrier.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {MOP_INV = 2'd0, MOP_CLEAN = 2'd1, MOP_FLUSH = 2'd2, MOP_NONE = 2'd3} mop_e;
  localparam logic LOP_CLEAN = 1'b0;
  localparam logic LOP_INV   = 1'b1;
  typedef enum logic [1:0] {K_NONE, K_CLEAN, K_INV, K_PAIR} kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_LINE} st_e;
endpackage

// File: rtl/crs_req_decode.sv
module crs_req_decode #(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 5
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] end_a,
  output logic [ADDR_W-1:0] start_al,
  output logic              head,
  output logic              walk
);
  import crs_pkg::*;
  localparam logic [ADDR_W-1:0] LMASK = ADDR_W'((1 << LINE_SHIFT) - 1);

  logic whole;
  always_comb begin
    start_al = start_a & ~LMASK;
    head     = (op == MOP_INV) && ((start_a & LMASK) != '0);
    whole    = (start_a == '0) && (end_a == '1);
    walk     = whole && ((op == MOP_INV) || (op == MOP_FLUSH));
  end
endmodule

// File: rtl/crs_line_math.sv
module crs_line_math #(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 5
) (
  input  logic [ADDR_W:0]   cur,
  input  logic [ADDR_W-1:0] end_a,
  input  logic [1:0]        mop,
  input  logic              head,
  output crs_pkg::kind_e    kind,
  output logic [ADDR_W:0]   nxt
);
  import crs_pkg::*;
  localparam logic [ADDR_W-1:0] LMASK = ADDR_W'((1 << LINE_SHIFT) - 1);
  localparam logic [ADDR_W:0]   STEP  = (ADDR_W+1)'(1 << LINE_SHIFT);

  logic [ADDR_W:0] end_ext, end_al;
  logic below, below_al;

  always_comb begin
    end_ext  = {1'b0, end_a};
    end_al   = {1'b0, end_a & ~LMASK};
    below    = cur < end_ext;
    below_al = cur < end_al;
    nxt      = cur + STEP;
    unique case (mop)
      MOP_CLEAN: kind = below ? K_CLEAN : K_NONE;
      MOP_FLUSH: kind = below ? K_PAIR : K_NONE;
      MOP_INV: begin
        if (head)          kind = K_PAIR;
        else if (below_al) kind = K_INV;
        else if (below)    kind = K_PAIR;
        else               kind = K_NONE;
      end
      default:   kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/crs_lop_reg.sv
module crs_lop_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_code,
  input  logic              lop_ready,
  output logic              lop_valid,
  output logic [ADDR_W-1:0] lop_addr,
  output logic              lop_code,
  output logic              free
);
  assign free = !lop_valid || lop_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      lop_valid <= 1'b0;
      lop_addr  <= '0;
      lop_code  <= 1'b0;
    end else if (load && free) begin
      lop_valid <= 1'b1;
      lop_addr  <= ld_addr;
      lop_code  <= ld_code;
    end else if (clear && free) begin
      lop_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    lop_valid && !lop_ready |=> lop_valid && $stable(lop_addr) && $stable(lop_code));
endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  output logic              busy,
  output logic              lop_valid,
  input  logic              lop_ready,
  output logic [ADDR_W-1:0] lop_addr,
  output logic              lop_code,
  output logic              walk_req,
  output logic              walk_flush,
  input  logic              walk_ack,
  output logic              done
);
  import crs_pkg::*;
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);

  st_e             st;
  logic [1:0]      mop_q;
  logic [ADDR_W:0] cur, nxt;
  logic [ADDR_W-1:0] end_q, start_al;
  logic            head_q, second_q, head_d, walk_d;
  kind_e           kind;
  logic            free, ld, ld_code;

  crs_req_decode #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)) u_dec (
    .op(req_op), .start_a(req_start), .end_a(req_end),
    .start_al(start_al), .head(head_d), .walk(walk_d)
  );

  crs_line_math #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)) u_math (
    .cur(cur), .end_a(end_q), .mop(mop_q), .head(head_q),
    .kind(kind), .nxt(nxt)
  );

  always_comb begin
    ld      = (st == ST_LINE) && (second_q || (kind != K_NONE));
    ld_code = (second_q || (kind == K_INV)) ? LOP_INV : LOP_CLEAN;
  end

  crs_lop_reg #(.ADDR_W(ADDR_W)) u_lop (
    .clk(clk), .rst(rst), .load(ld), .clear(1'b1),
    .ld_addr(cur[ADDR_W-1:0]), .ld_code(ld_code), .lop_ready(lop_ready),
    .lop_valid(lop_valid), .lop_addr(lop_addr), .lop_code(lop_code), .free(free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      walk_req   <= 1'b0;
      walk_flush <= 1'b0;
      cur        <= '0;
      end_q      <= '0;
      mop_q      <= MOP_NONE;
      head_q     <= 1'b0;
      second_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          busy     <= 1'b1;
          mop_q    <= req_op;
          cur      <= {1'b0, start_al};
          end_q    <= req_end;
          head_q   <= head_d;
          second_q <= 1'b0;
          if (walk_d) begin
            st         <= ST_WALK;
            walk_req   <= 1'b1;
            walk_flush <= (req_op == MOP_FLUSH);
          end else begin
            st <= ST_LINE;
          end
        end
        ST_WALK: if (walk_ack) begin
          walk_req <= 1'b0;
          done     <= 1'b1;
          busy     <= 1'b0;
          st       <= ST_IDLE;
        end
        ST_LINE: if (free) begin
          if (second_q) begin
            second_q <= 1'b0;
            cur      <= nxt;
          end else begin
            unique case (kind)
              K_CLEAN, K_INV: cur <= nxt;
              K_PAIR: begin
                second_q <= 1'b1;
                head_q   <= 1'b0;
              end
              default: begin
                done <= 1'b1;
                busy <= 1'b0;
                st   <= ST_IDLE;
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_idle_r7:  assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  p_walk_hold_r6:  assert property (@(posedge clk) disable iff (rst)
    walk_req && !walk_ack |=> walk_req && $stable(walk_flush));
  p_walk_excl_r6:  assert property (@(posedge clk) disable iff (rst) walk_req |-> !lop_valid);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !lop_valid && !walk_req);
  p_align_r1:      assert property (@(posedge clk) disable iff (rst)
    lop_valid |-> lop_addr[LINE_SHIFT-1:0] == '0);
  p_pair_r2:       assert property (@(posedge clk) disable iff (rst)
    lop_valid && lop_ready && lop_code == LOP_CLEAN && second_q |=>
      lop_valid && lop_code == LOP_INV && lop_addr == $past(lop_addr));
endmodule

// File: tb/sim_cache_range_seq.sv
`timescale 1ns/1ps
module sim_cache_range_seq;
  logic        clk = 0, rst = 1;
  logic        req_valid = 0;
  logic [1:0]  req_op = 0;
  logic [31:0] req_start = 0, req_end = 0;
  logic        busy, lop_valid, lop_code, walk_req, walk_flush, done;
  logic        lop_ready = 1, walk_ack = 0;
  logic [31:0] lop_addr;

  cache_range_seq #(.ADDR_W(32), .LINE_BYTES(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_start(req_start), .req_end(req_end), .busy(busy),
    .lop_valid(lop_valid), .lop_ready(lop_ready), .lop_addr(lop_addr),
    .lop_code(lop_code), .walk_req(walk_req), .walk_flush(walk_flush),
    .walk_ack(walk_ack), .done(done)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, n_hs = 0, n_done = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  bit          walk_exp = 0, walk_exp_flush = 0, prev_walk = 0;
  bit          prev_stall = 0, prev_code = 0;
  logic [31:0] prev_addr = 0;
  int          due_cnt = 0, stall_mode = 0, wcnt = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void push(longint a, bit c, string t);
    exp_q.push_back({c, a[31:0]});
    tag_q.push_back(t);
  endfunction

  // reference: walk the range the way the requirements describe it
  function automatic void gen(int op, longint s, longint e);
    if (op == 1) begin
      s = s & ~longint'(31);
      while (s < e) begin push(s, 0, "R1"); s += 32; end
    end else if (op == 2) begin
      s = s & ~longint'(31);
      while (s < e) begin push(s, 0, "R2"); push(s, 1, "R2"); s += 32; end
    end else if (op == 0) begin
      if ((s & 31) != 0) begin
        push(s & ~longint'(31), 0, "R3"); push(s & ~longint'(31), 1, "R3");
        s = (s | 31) + 1;
      end
      while (s < (e & ~longint'(31))) begin push(s, 1, "R4"); s += 32; end
      if (s < e) begin push(s, 0, "R5"); push(s, 1, "R5"); end
    end
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    bit due;
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
    if (!rst) begin
      if (prev_stall)
        chk(lop_valid && lop_addr == prev_addr && lop_code == prev_code, "R9",
            "command changed under stall", {lop_code, lop_addr}, {prev_code, prev_addr});
      due = 0;
      if (due_cnt > 0) begin due_cnt--; if (due_cnt == 0) due = 1; end
      if (due) chk(done, "R7", "done missing", done, 1);
      else if (done) chk(0, "R7", "spurious done", done, 0);
      if (done) n_done++;
      if (lop_valid && !busy) chk(0, "R8", "command while idle", lop_valid, 0);
      if (lop_valid && lop_ready) begin
        n_hs++;
        if (exp_q.size() == 0) chk(0, "R8", "unexpected command", lop_addr, 0);
        else begin
          logic [32:0] x; string t;
          x = exp_q.pop_front(); t = tag_q.pop_front();
          chk(lop_addr == x[31:0] && lop_code == x[32], t, "line command",
              {lop_code, lop_addr}, x);
          if (exp_q.size() == 0) due_cnt = 1;
        end
      end
      if (walk_req && !prev_walk)
        chk(walk_exp && walk_flush == walk_exp_flush, "R6", "walk request",
            {walk_exp, walk_flush}, {1'b1, walk_exp_flush});
      if (walk_req && walk_ack) begin walk_exp = 0; due_cnt = 1; end
      if (req_valid && !busy) begin
        if ((req_op == 0 || req_op == 2) && req_start == 0 && req_end == 32'hFFFFFFFF) begin
          walk_exp = 1; walk_exp_flush = (req_op == 2);
        end else begin
          gen(req_op, req_start, req_end);
          if (exp_q.size() == 0) due_cnt = 2;
        end
      end
      prev_walk  = walk_req;
      prev_stall = lop_valid && !lop_ready;
      prev_addr  = lop_addr;
      prev_code  = lop_code;
    end
  end

  always @(posedge clk) begin
    #1;
    lop_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    walk_ack  = 0;
    if (walk_req) begin
      wcnt++;
      if (wcnt == 3) walk_ack = 1;
    end else wcnt = 0;
  end

  task automatic issue(int op, longint s, longint e);
    @(posedge clk); #1;
    req_op = op[1:0]; req_start = s[31:0]; req_end = e[31:0]; req_valid = 1;
    do @(negedge clk); while (busy);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_done();
    int n;
    n = n_done;
    while (n_done == n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int h;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!busy && !lop_valid && !done && !walk_req, "R8", "reset state",
        {busy, lop_valid, done, walk_req}, 0);

    issue(1, 32'h1004, 32'h1050); wait_done();     // R1 three cleans
    issue(2, 32'h2010, 32'h2040); wait_done();     // R2 two pairs
    issue(0, 32'h3004, 32'h3088); wait_done();     // R3 R4 R5
    issue(0, 32'h4000, 32'h4040); wait_done();     // R4 only
    issue(0, 32'h5005, 32'h5010); wait_done();     // R3 single line
    issue(0, 0, 32'hFFFFFFFF); wait_done();        // R6 invalidate all
    issue(2, 0, 32'hFFFFFFFF); wait_done();        // R6 flush all
    h = n_hs;
    issue(1, 32'h6040, 32'h6020); wait_done();     // R1 empty range
    chk(n_hs == h, "R1", "empty clean issued commands", n_hs - h, 0);
    h = n_hs;
    issue(3, 32'h7000, 32'h7100); wait_done();     // R10
    chk(n_hs == h && !walk_req, "R10", "no-op issued commands", n_hs - h, 0);

    stall_mode = 1;
    issue(2, 32'h8000, 32'h80A0); wait_done();     // R2 R9 under stalls
    issue(0, 32'h9013, 32'h90F1); wait_done();     // R3 R4 R5 R9 under stalls

    // R8: request pulsed while busy is ignored
    issue(1, 32'hA000, 32'hA200);
    repeat (2) @(posedge clk);
    #1 req_op = 2; req_start = 32'hB000; req_end = 32'hB100; req_valid = 1;
    @(negedge clk);
    chk(busy, "R8", "busy during request", busy, 1);
    @(posedge clk); #1 req_valid = 0;
    wait_done();
    repeat (6) @(negedge clk);
    chk(!busy && !lop_valid && exp_q.size() == 0, "R8", "ignored request acted",
        {busy, lop_valid}, 0);

    // back-to-back: second request held, taken in the done cycle
    stall_mode = 0;
    issue(0, 32'hC008, 32'hC068);
    issue(1, 32'hD000, 32'hD060);
    wait_done();
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !busy, "R7", "back-to-back drained", exp_q.size(), 0);
    summary();
  end
endmodule